// File: doc/BRIEF.md
# Flag Offset Loader

This block sets up the two threshold values a FIFO uses for its early-warning flags: the almost-empty offset (X) and the almost-full offset (Y). The method is fixed while reset is held. A two-bit select code either names one of three preset values, which are then written into both offsets, or hands the choice to a mode input. That input picks a load from the write-side data bus or a bit-serial load through a dedicated enable and data pin pair. All loading is synchronous to the write clock.

Once the offsets hold their final values, a done output goes high and stays high until the next reset. The FIFO storage and the flag comparators that use X and Y live outside this block.

Top module: `flagoffset_loader`

## Requirements
- R1: The select code and the mode input are sampled on every clock edge while `rstN` is low. The values from the last edge in reset fix the method, and changing them after reset has no effect.
- R2: Select code 00 loads 64, code 01 loads 16 and code 10 loads 8 into both `offAe` and `offAf` during reset. `progDone` is high in the first cycle after reset is released.
- R3: With select code 11, both offsets are 0 and `progDone` is low after reset.
- R4: Parallel method (code 11, `serialMode` low): the first clock edge with `wrStb` high loads `wrData[OFF_W-1:0]` into `offAe`. The new value is visible after that edge.
- R5: Parallel method: the second clock edge with `wrStb` high loads `wrData[OFF_W-1:0]` into `offAf` and sets `progDone` on the same edge.
- R6: Serial method (code 11, `serialMode` high): each clock edge with `serEnN` low shifts `serData` into the combined register {`offAf`,`offAe`}. The first bit ends at the MSB of `offAf` and the last bit at the LSB of `offAe`.
- R7: Serial method: `progDone` rises on the edge that takes bit number 2*OFF_W (18 by default) and not before.
- R8: Once `progDone` is high, further `wrStb` and `serEnN` activity leaves both offsets unchanged until the next reset.
- R9: In serial mode `wrStb` is ignored. In parallel mode `serEnN` is ignored.
- R10: `progDone` never falls except through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rstN | input | 1 | Synchronous reset, active low |
| selCode | input | 2 | Preset / method select, sampled in reset |
| serialMode | input | 1 | With code 11: high selects serial, low selects parallel |
| serEnN | input | 1 | Serial shift enable, active low |
| serData | input | 1 | Serial data bit |
| wrStb | input | 1 | Qualified write-bus strobe |
| wrData | input | DATA_W | Write data bus |
| offAe | output | OFF_W | Almost-empty offset X |
| offAf | output | OFF_W | Almost-full offset Y |
| progDone | output | 1 | Offsets are final |

## Verification
Preset values and the done flag are already in place during reset, so the bench checks them on the first falling edge after release. Every parallel write and every serial bit is registered once. Its effect is due one edge after the strobe, and the bench drives on the falling edge and samples on the next falling edge, half a cycle after the register updates. The done flag rises on the same edge as the final write or final bit, so it is checked one sample before that edge (still low) and one sample after (high). Serial runs mix in random idle cycles and stray write strobes to show that only enabled edges count.

// File: rtl/offprog_pkg.sv
package offprog_pkg;
  typedef enum logic [1:0] {M_PRESET, M_PARALLEL, M_SERIAL} method_e;

  typedef struct packed {
    logic clear;
    logic loadPreset;
    logic loadX;
    logic loadY;
    logic shift;
  } strobe_t;
endpackage

// File: rtl/offprog_ctrl.sv
module offprog_ctrl
  import offprog_pkg::*;
#(
  parameter int OFF_W = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] selCode,
  input  logic       serialMode,
  input  logic       serEnN,
  input  logic       wrStb,
  output strobe_t    stb,
  output logic       progDone
);
  localparam int TOTAL_BITS = 2 * OFF_W;
  localparam int CNT_W = $clog2(TOTAL_BITS + 1);

  method_e          method;
  logic [CNT_W-1:0] stepCnt;
  logic             lastStep;

  always_comb begin
    stb = '0;
    if (!rstN) begin
      stb.clear      = (selCode == 2'b11);
      stb.loadPreset = (selCode != 2'b11);
    end else if (!progDone) begin
      case (method)
        M_PARALLEL: begin
          stb.loadX = wrStb && (stepCnt == '0);
          stb.loadY = wrStb && (stepCnt == CNT_W'(1));
        end
        M_SERIAL: stb.shift = !serEnN;
        default: ;
      endcase
    end
  end

  assign lastStep = stb.loadY || (stb.shift && (stepCnt == CNT_W'(TOTAL_BITS - 1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      if (selCode != 2'b11) method <= M_PRESET;
      else                  method <= serialMode ? M_SERIAL : M_PARALLEL;
      stepCnt  <= '0;
      progDone <= (selCode != 2'b11);
    end else begin
      if (stb.loadX || stb.loadY || stb.shift) stepCnt <= stepCnt + 1'b1;
      if (lastStep) progDone <= 1'b1;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    progDone |=> progDone); // R10

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadX, stb.loadY, stb.shift})); // R9

  AST_SERIAL_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (method == M_SERIAL && $rose(progDone)) |-> ($past(stepCnt) == CNT_W'(TOTAL_BITS - 1))); // R7

  AST_NO_LOAD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    progDone |-> !(stb.loadX || stb.loadY || stb.shift)); // R8
endmodule

// File: rtl/offprog_dp.sv
module offprog_dp
  import offprog_pkg::*;
#(
  parameter int OFF_W  = 9,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [1:0]        selCode,
  input  logic [DATA_W-1:0] wrData,
  input  logic              serData,
  output logic [OFF_W-1:0]  offAe,
  output logic [OFF_W-1:0]  offAf
);
  logic [OFF_W-1:0] presetVal;

  always_comb begin
    case (selCode)
      2'b00:   presetVal = OFF_W'(64);
      2'b01:   presetVal = OFF_W'(16);
      2'b10:   presetVal = OFF_W'(8);
      default: presetVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (stb.clear) begin
      offAe <= '0;
      offAf <= '0;
    end else if (stb.loadPreset) begin
      offAe <= presetVal;
      offAf <= presetVal;
    end else if (stb.loadX) begin
      offAe <= wrData[OFF_W-1:0];
    end else if (stb.loadY) begin
      offAf <= wrData[OFF_W-1:0];
    end else if (stb.shift) begin
      {offAf, offAe} <= {offAf[OFF_W-2:0], offAe, serData};
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stb == '0) |=> $stable({offAf, offAe})); // R8

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |=> (offAe[0] == $past(serData))); // R6
endmodule

// File: rtl/flagoffset_loader.sv
module flagoffset_loader
  import offprog_pkg::*;
#(
  parameter int OFF_W  = 9,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        selCode,
  input  logic              serialMode,
  input  logic              serEnN,
  input  logic              serData,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  output logic [OFF_W-1:0]  offAe,
  output logic [OFF_W-1:0]  offAf,
  output logic              progDone
);
  strobe_t stb;

  offprog_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .selCode(selCode), .serialMode(serialMode),
    .serEnN(serEnN), .wrStb(wrStb), .stb(stb), .progDone(progDone)
  );

  offprog_dp #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .selCode(selCode), .wrData(wrData),
    .serData(serData), .offAe(offAe), .offAf(offAf)
  );
endmodule

// File: tb/flagoffset_loader_tb.sv
module flagoffset_loader_tb;
  localparam int OFF_W  = 9;
  localparam int DATA_W = 36;
  localparam int NBITS  = 2 * OFF_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        selCode = 2'b00;
  logic              serialMode = 1'b0;
  logic              serEnN = 1'b1;
  logic              serData = 1'b0;
  logic              wrStb = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [OFF_W-1:0]  offAe, offAf;
  logic              progDone;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flagoffset_loader #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .selCode(selCode), .serialMode(serialMode),
    .serEnN(serEnN), .serData(serData), .wrStb(wrStb), .wrData(wrData),
    .offAe(offAe), .offAf(offAf), .progDone(progDone)
  );

  function automatic logic [OFF_W-1:0] presetOf(input logic [1:0] code);
    case (code)
      2'b00:   return OFF_W'(64);
      2'b01:   return OFF_W'(16);
      2'b10:   return OFF_W'(8);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input logic [1:0] code, input logic mode);
    @(negedge clk);
    rstN = 1'b0; selCode = code; serialMode = mode;
    serEnN = 1'b1; wrStb = 1'b0;
    step(); step(); step();
    rstN = 1'b1;
    selCode = ~code;          // R1: changes after reset must not matter
    serialMode = ~mode;
  endtask

  task automatic checkOffsets(input string req, input logic [OFF_W-1:0] ex,
                              input logic [OFF_W-1:0] ey, input logic ed);
    check({req, " offAe"}, 32'(offAe), 32'(ex));
    check({req, " offAf"}, 32'(offAf), 32'(ey));
    check({req, " progDone"}, 32'(progDone), 32'(ed));
  endtask

  // Disturb with stray strobes: shift enables and bus writes, random data.
  task automatic disturb(input int n);
    for (int i = 0; i < n; i++) begin
      serEnN = $urandom_range(1, 0);
      serData = $urandom_range(1, 0);
      wrStb = $urandom_range(1, 0);
      wrData = {$urandom(), $urandom()};
      step();
    end
    serEnN = 1'b1; wrStb = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    // Preset methods: R2, R1, R8, R10
    for (int c = 0; c < 3; c++) begin
      doReset(2'(c), c[0]);
      checkOffsets("R2 preset", presetOf(2'(c)), presetOf(2'(c)), 1'b1);
      disturb(6);
      checkOffsets("R8 R10 R1 preset hold", presetOf(2'(c)), presetOf(2'(c)), 1'b1);
    end

    // Parallel method: R3, R9, R4, R5, R8
    for (int it = 0; it < 3; it++) begin
      logic [DATA_W-1:0] d1, d2;
      doReset(2'b11, 1'b0);
      checkOffsets("R3 cleared", '0, '0, 1'b0);
      for (int i = 0; i < 5; i++) begin
        serEnN = $urandom_range(1, 0); serData = $urandom_range(1, 0);
        step();
      end
      serEnN = 1'b1;
      checkOffsets("R9 serial ignored in parallel", '0, '0, 1'b0);
      d1 = {$urandom(), $urandom()};
      d2 = (it == 0) ? '1 : {$urandom(), $urandom()};
      wrData = d1; wrStb = 1'b1; step(); wrStb = 1'b0;
      wrData = {$urandom(), $urandom()};
      checkOffsets("R4 first write", d1[OFF_W-1:0], '0, 1'b0);
      step();
      wrData = d2; wrStb = 1'b1; step(); wrStb = 1'b0;
      checkOffsets("R5 second write", d1[OFF_W-1:0], d2[OFF_W-1:0], 1'b1);
      disturb(8);
      checkOffsets("R8 R10 parallel hold", d1[OFF_W-1:0], d2[OFF_W-1:0], 1'b1);
    end

    // Serial method: R6, R7, R9, R8
    for (int it = 0; it < 4; it++) begin
      logic [NBITS-1:0] vec;
      vec = (it == 0) ? NBITS'(1) << (NBITS - 1) : (it == 1) ? NBITS'(1) : NBITS'($urandom());
      doReset(2'b11, 1'b1);
      checkOffsets("R3 cleared serial", '0, '0, 1'b0);
      for (int b = 0; b < NBITS; b++) begin
        if ($urandom_range(1, 0) == 1) begin
          serEnN = 1'b1; serData = $urandom_range(1, 0);
          wrStb = 1'b1; wrData = {$urandom(), $urandom()};
          step();
          wrStb = 1'b0;
        end
        if (b == NBITS - 1) check("R7 not done before last bit", 32'(progDone), 32'd0);
        serEnN = 1'b0; serData = vec[NBITS-1-b];
        step();
        serEnN = 1'b1;
      end
      checkOffsets("R6 R7 R9 serial result", vec[OFF_W-1:0], vec[NBITS-1:OFF_W], 1'b1);
      disturb(10);
      checkOffsets("R8 R10 serial hold", vec[OFF_W-1:0], vec[NBITS-1:OFF_W], 1'b1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule